// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer for a processor core that executes each instruction over several clock cycles on a shared datapath. The datapath has one ALU, one memory port, an instruction register and a program counter. The sequencer is a Moore machine. It reads the 6-bit operation code held in the instruction register and steps through a fixed set of numbered states. In each state it drives the write strobes, mux selects and ALU mode for the datapath around it.

Every instruction goes through the same two opening states: fetch, then decode. During decode the ALU forms a branch target in advance, whether or not the instruction is a branch. After decode the sequencer dispatches on the operation code to one of five paths:

| Instruction class | Cycles |
|---|---|
| Load | 5 |
| Store | 4 |
| Register-to-register | 4 |
| Branch | 3 |
| Jump | 3 |

The surrounding datapath, the memories, the register file and the secondary ALU decode of the function field all sit outside this block. The state number is brought out so that neighbouring logic and test equipment can follow the sequence.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer enters state 0 and presents the state 0 control values in the following cycle. This takes priority over every transition, including a dispatch out of state 1.
- R2: State 0 (fetch) drives `mem_rd`=1, `instr_we`=1 and `pc_we`=1, with `alu_a_sel`=0, `alu_b_sel`=01, `alu_mode`=00, `addr_sel_data`=0 and `pc_next_sel`=00. It always moves to state 1.
- R3: State 1 (decode) drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_mode`=00, with every strobe at 0, whatever the operation code is.
- R4: From state 1 the next state depends on the operation code. Code 0x23 or 0x2B goes to state 2, code 0x00 goes to state 6, code 0x04 goes to state 8 and code 0x02 goes to state 9. Any other code returns to state 0.
- R5: State 2 (address) drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00. It moves to state 3 for code 0x23, to state 5 for code 0x2B, and to state 0 for anything else.
- R6: State 3 (load read) drives `addr_sel_data`=1 and `mem_rd`=1, then moves to state 4. State 4 (load write-back) drives `rf_we`=1, `wb_from_mem`=1 and `dst_sel_rd`=0, then always returns to state 0.
- R7: State 5 (store) drives `addr_sel_data`=1 and `mem_wr`=1, then returns to state 0.
- R8: State 6 (execute) drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10, then moves to state 7. State 7 drives `rf_we`=1, `dst_sel_rd`=1 and `wb_from_mem`=0, then returns to state 0.
- R9: State 8 (branch) drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_we_cond`=1 and `pc_next_sel`=01, then returns to state 0.
- R10: State 9 (jump) drives `pc_we`=1 and `pc_next_sel`=10, then returns to state 0.
- R11: The strobes `pc_we`, `pc_we_cond`, `mem_rd`, `mem_wr`, `instr_we` and `rf_we` are 0 in every state where they are not named above. Selects and the ALU mode that are not named for a state are driven to 0.
- R12: Counted from one entry into state 0 to the next, the sequence takes 5 cycles for a load, 4 for a store, 4 for a register-to-register operation, 3 for a branch or a jump, and 2 for an unrecognised code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W (6) | Operation code from the instruction register |
| state_o | output | 4 | Current state number (0 to 9) |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_cond | output | 1 | Program counter write, qualified by the ALU zero flag |
| addr_sel_data | output | 1 | Memory address from the ALU result register instead of the program counter |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| instr_we | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data taken from the memory data register |
| dst_sel_rd | output | 1 | Destination register taken from the third register field |
| rf_we | output | 1 | Register file write strobe |
| alu_a_sel | output | 1 | ALU first operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU second operand: 00 register B, 01 constant 4, 10 offset, 11 shifted offset |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 follow the function field |
| pc_next_sel | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump address |

## Verification
The bench can raise reset in the same cycle that the sequencer sits in decode with a valid operation code present. In that cycle the dispatch and the reset compete for the state register. The bench provokes this once at decode and once in the middle of a load. It judges the result by whether the next cycle shows state 0 with the fetch controls (reset wins) or shows the dispatched state. Fetch itself combines three writes in a single cycle: the program counter, the instruction register and the memory read. The cycle-by-cycle model compares all of them together on every clock.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int STATE_W = 4;
  localparam int BSEL_W  = 2;
  localparam int MODE_W  = 2;
  localparam int PSEL_W  = 2;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_ALU   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BRNCH = 6'h04;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_LD_RD   = 4'd3,
    ST_LD_WB   = 4'd4,
    ST_STORE   = 4'd5,
    ST_EXEC    = 4'd6,
    ST_ALU_WB  = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9
  } state_t;

  typedef enum logic [2:0] {
    CL_LOAD, CL_STORE, CL_ALU, CL_BRANCH, CL_JUMP, CL_OTHER
  } op_class_t;

  localparam logic [BSEL_W-1:0] B_REG   = 2'b00;
  localparam logic [BSEL_W-1:0] B_FOUR  = 2'b01;
  localparam logic [BSEL_W-1:0] B_OFS   = 2'b10;
  localparam logic [BSEL_W-1:0] B_OFS_S = 2'b11;

  localparam logic [MODE_W-1:0] M_ADD   = 2'b00;
  localparam logic [MODE_W-1:0] M_SUB   = 2'b01;
  localparam logic [MODE_W-1:0] M_FUNCT = 2'b10;

  localparam logic [PSEL_W-1:0] P_ALU   = 2'b00;
  localparam logic [PSEL_W-1:0] P_HOLD  = 2'b01;
  localparam logic [PSEL_W-1:0] P_JUMP  = 2'b10;

  typedef struct packed {
    logic              pc_we;
    logic              pc_we_cond;
    logic              addr_sel_data;
    logic              mem_rd;
    logic              mem_wr;
    logic              instr_we;
    logic              wb_from_mem;
    logic              dst_sel_rd;
    logic              rf_we;
    logic              alu_a_sel;
    logic [BSEL_W-1:0] alu_b_sel;
    logic [MODE_W-1:0] alu_mode;
    logic [PSEL_W-1:0] pc_next_sel;
  } ctl_t;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_ctrl_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic [OP_W-1:0] opcode,
  output op_class_t       op_class
);

  always_comb begin
    if (opcode == OP_W'(OPC_LOAD))       op_class = CL_LOAD;
    else if (opcode == OP_W'(OPC_STORE)) op_class = CL_STORE;
    else if (opcode == OP_W'(OPC_ALU))   op_class = CL_ALU;
    else if (opcode == OP_W'(OPC_BRNCH)) op_class = CL_BRANCH;
    else if (opcode == OP_W'(OPC_JUMP))  op_class = CL_JUMP;
    else                                 op_class = CL_OTHER;
  end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_t    state_q,
  input  op_class_t op_class,
  output state_t    state_d
);

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (op_class)
          CL_LOAD, CL_STORE: state_d = ST_ADDR;
          CL_ALU:            state_d = ST_EXEC;
          CL_BRANCH:         state_d = ST_BRANCH;
          CL_JUMP:           state_d = ST_JUMP;
          default:           state_d = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        if (op_class == CL_LOAD)       state_d = ST_LD_RD;
        else if (op_class == CL_STORE) state_d = ST_STORE;
        else                           state_d = ST_FETCH;
      end
      ST_LD_RD:  state_d = ST_LD_WB;
      ST_EXEC:   state_d = ST_ALU_WB;
      default:   state_d = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctl_decode.sv
module mc_ctl_decode
  import mc_ctrl_pkg::*;
(
  input  state_t state,
  output ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.instr_we  = 1'b1;
        ctl.pc_we     = 1'b1;
        ctl.alu_b_sel = B_FOUR;
        ctl.alu_mode  = M_ADD;
      end
      ST_DECODE: begin
        ctl.alu_b_sel = B_OFS_S;
        ctl.alu_mode  = M_ADD;
      end
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = B_OFS;
        ctl.alu_mode  = M_ADD;
      end
      ST_LD_RD: begin
        ctl.addr_sel_data = 1'b1;
        ctl.mem_rd        = 1'b1;
      end
      ST_LD_WB: begin
        ctl.rf_we       = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      ST_STORE: begin
        ctl.addr_sel_data = 1'b1;
        ctl.mem_wr        = 1'b1;
      end
      ST_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = B_REG;
        ctl.alu_mode  = M_FUNCT;
      end
      ST_ALU_WB: begin
        ctl.rf_we      = 1'b1;
        ctl.dst_sel_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_a_sel   = 1'b1;
        ctl.alu_b_sel   = B_REG;
        ctl.alu_mode    = M_SUB;
        ctl.pc_we_cond  = 1'b1;
        ctl.pc_next_sel = P_HOLD;
      end
      ST_JUMP: begin
        ctl.pc_we       = 1'b1;
        ctl.pc_next_sel = P_JUMP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  output logic [STATE_W-1:0] state_o,
  output logic              pc_we,
  output logic              pc_we_cond,
  output logic              addr_sel_data,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              instr_we,
  output logic              wb_from_mem,
  output logic              dst_sel_rd,
  output logic              rf_we,
  output logic              alu_a_sel,
  output logic [BSEL_W-1:0] alu_b_sel,
  output logic [MODE_W-1:0] alu_mode,
  output logic [PSEL_W-1:0] pc_next_sel
);

  state_t    state_q, state_d;
  op_class_t op_class;
  ctl_t      ctl_d, ctl_q, ctl_fetch;

  mc_op_classify #(.OP_W(OP_W)) u_class (
    .opcode   (opcode),
    .op_class (op_class)
  );

  mc_next_state u_next (
    .state_q  (state_q),
    .op_class (op_class),
    .state_d  (state_d)
  );

  // Outputs are registered: decode the state being entered.
  mc_ctl_decode u_dec_next (
    .state (state_d),
    .ctl   (ctl_d)
  );

  mc_ctl_decode u_dec_rst (
    .state (ST_FETCH),
    .ctl   (ctl_fetch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      ctl_q   <= ctl_fetch;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  assign state_o       = state_q;
  assign pc_we         = ctl_q.pc_we;
  assign pc_we_cond    = ctl_q.pc_we_cond;
  assign addr_sel_data = ctl_q.addr_sel_data;
  assign mem_rd        = ctl_q.mem_rd;
  assign mem_wr        = ctl_q.mem_wr;
  assign instr_we      = ctl_q.instr_we;
  assign wb_from_mem   = ctl_q.wb_from_mem;
  assign dst_sel_rd    = ctl_q.dst_sel_rd;
  assign rf_we         = ctl_q.rf_we;
  assign alu_a_sel     = ctl_q.alu_a_sel;
  assign alu_b_sel     = ctl_q.alu_b_sel;
  assign alu_mode      = ctl_q.alu_mode;
  assign pc_next_sel   = ctl_q.pc_next_sel;

  // R1: a reset cycle is always followed by fetch
  p_reset_to_fetch_r1: assert property (@(posedge clk)
    rst |=> (state_q == ST_FETCH && instr_we && mem_rd));

  // R2: the fetch state carries its three writes
  p_fetch_writes_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |-> (mem_rd && instr_we && pc_we && !mem_wr));

  // R2: fetch is always followed by decode
  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  // R3: decode is only entered from fetch
  p_decode_from_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE) |-> ($past(state_q) == ST_FETCH));

  // R4: branch code in decode leads to the branch state
  p_dispatch_branch_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE && opcode == OP_W'(OPC_BRNCH)) |=> (state_q == ST_BRANCH));

  // R6: load read is followed by load write-back
  p_load_seq_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LD_RD) |=> (state_q == ST_LD_WB && rf_we && wb_from_mem));

  // R11: memory is never read and written together
  p_mem_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R11: at most one architectural write strobe besides the fetch group
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, rf_we, pc_we_cond, instr_we}));

  // R12: every terminal state returns to fetch
  p_terminal_return_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {ST_LD_WB, ST_STORE, ST_ALU_WB, ST_BRANCH, ST_JUMP})
      |=> (state_q == ST_FETCH));

endmodule

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [3:0] state_o;
  logic pc_we, pc_we_cond, addr_sel_data, mem_rd, mem_wr, instr_we;
  logic wb_from_mem, dst_sel_rd, rf_we, alu_a_sel;
  logic [1:0] alu_b_sel, alu_mode, pc_next_sel;

  int checks = 0;
  int errors = 0;
  int ref_state = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm #(.OP_W(6)) dut (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .addr_sel_data(addr_sel_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .instr_we(instr_we),
    .wb_from_mem(wb_from_mem), .dst_sel_rd(dst_sel_rd), .rf_we(rf_we),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_mode(alu_mode),
    .pc_next_sel(pc_next_sel)
  );

  // Order: pc_we pc_we_cond addr mem_rd mem_wr instr_we wbmem dst rf_we a b[2] mode[2] psel[2]
  function automatic logic [15:0] exp_ctl(input int s);
    case (s)
      0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00};
      1: return {9'b0,1'b0,2'b11,2'b00,2'b00};
      2: return {9'b0,1'b1,2'b10,2'b00,2'b00};
      3: return {1'b0,1'b0,1'b1,1'b1,12'b0};
      4: return {6'b0,1'b1,1'b0,1'b1,7'b0};
      5: return {1'b0,1'b0,1'b1,1'b0,1'b1,11'b0};
      6: return {9'b0,1'b1,2'b00,2'b10,2'b00};
      7: return {7'b0,1'b1,1'b1,7'b0};
      8: return {1'b0,1'b1,7'b0,1'b1,2'b00,2'b01,2'b01};
      9: return {1'b1,13'b0,2'b10};
      default: return 16'h0;
    endcase
  endfunction

  function automatic int exp_next(input int s, input logic [5:0] op, input logic r);
    if (r) return 0;
    case (s)
      0: return 1;
      1: begin
        if (op == 6'h23 || op == 6'h2B) return 2;
        if (op == 6'h00) return 6;
        if (op == 6'h04) return 8;
        if (op == 6'h02) return 9;
        return 0;
      end
      2: return (op == 6'h23) ? 3 : (op == 6'h2B) ? 5 : 0;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      9: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] act_ctl();
    return {pc_we, pc_we_cond, addr_sel_data, mem_rd, mem_wr, instr_we,
            wb_from_mem, dst_sel_rd, rf_we, alu_a_sel, alu_b_sel, alu_mode, pc_next_sel};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock: drive inputs, advance the model, compare after the edge.
  task automatic step(input logic [5:0] op, input logic r, input string req_override);
    int nxt;
    string rq;
    opcode = op;
    rst    = r;
    nxt = exp_next(ref_state, op, r);
    @(posedge clk);
    @(negedge clk);
    ref_state = nxt;
    rq = (req_override.len() > 0) ? req_override : req_of(ref_state);
    check(rq, "state", int'(state_o), ref_state);
    check(rq, "controls", int'(act_ctl()), int'(exp_ctl(ref_state)));
  endtask

  // R12: cycles from fetch back to fetch
  task automatic run_instr(input logic [5:0] op, input int exp_len, input string req);
    int n = 0;
    do begin
      step(op, 1'b0, "");
      n++;
    end while (state_o != 4'd0 && n < 12);
    check(req, "latency", n, exp_len);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(6'h00, 1'b1, "R1");
    step(6'h23, 1'b1, "R1");
    // Main function across all instruction classes
    run_instr(6'h23, 5, "R12");
    run_instr(6'h2B, 4, "R12");
    run_instr(6'h00, 4, "R12");
    run_instr(6'h04, 3, "R12");
    run_instr(6'h02, 3, "R12");
    // R4: unrecognised codes return to fetch
    run_instr(6'h3F, 2, "R4");
    run_instr(6'h08, 2, "R4");
    // R3: decode controls do not depend on the code present
    step(6'h3F, 1'b0, "R3");
    step(6'h3F, 1'b0, "R4");
    // R1: reset in decode with a valid code beats the dispatch
    step(6'h04, 1'b0, "R3");
    step(6'h04, 1'b1, "R1");
    // R1: reset in the middle of a load
    step(6'h23, 1'b0, "R2");
    step(6'h23, 1'b0, "R5");
    step(6'h23, 1'b0, "R6");
    step(6'h23, 1'b1, "R1");
    // Back-to-back mixed sequence after reset
    run_instr(6'h2B, 4, "R7");
    run_instr(6'h23, 5, "R6");
    run_instr(6'h02, 3, "R10");
    run_instr(6'h04, 3, "R9");
    run_instr(6'h00, 4, "R8");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule